// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Chain

This block is a chain of identical 4-bit synchronous counter stages that behaves as one wider binary counter. The counter counts up or down. It can be preset from a parallel data word, and it holds its value when either of its two active-low count enables is high. Every stage samples its controls on the rising edge of one shared clock. Changes on the load, enable or direction inputs therefore have no effect on the count until the next edge.

Each stage reports whether it sits at its terminal value: all ones when counting up, all zeros when counting down. An active-low carry leaves the chain when the carry-gating enable is low and the whole count is terminal. The carry is combinational in the count and the direction, so it can gate the enable of a following chain, or drive its load, with no extra logic. Inside the chain, a parameter sets how each stage's carry-gating enable is formed. One choice passes it from stage to stage. The other computes it for every stage in parallel from the terminal flags of all lower stages.

A synchronous active-high reset clears the count for simulation start-up.

Top module: `updn_chain`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes all zeros. Reset overrides load and count.
- R2: When `rst` is low and `ld_n` is low at a rising edge, `q` takes the value of `d`. This happens whatever `en_p_n`, `en_t_n` and `up` are, so a load never counts.
- R3: With `ld_n` high and both `en_p_n` and `en_t_n` low, `up`=1 adds one to `q` at each rising edge, modulo 2^(4·STAGES). A stage that passes from 15 to 0 carries into the stage above it in the same edge.
- R4: Under the same enables, `up`=0 subtracts one from `q` at each rising edge, modulo 2^(4·STAGES). All zeros wraps to all ones.
- R5: With `ld_n` high and `en_p_n` high, `q` holds its value.
- R6: With `ld_n` high and `en_t_n` high, `q` holds its value and `tc_n` is high.
- R7: `tc_n` is low exactly when `en_t_n` is low and either `up`=1 with `q` all ones, or `up`=0 with `q` all zeros. The level of `en_p_n` does not affect `tc_n`.
- R8: `tc_n` follows a change on `up` (or `en_t_n`) within the same clock phase, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by every stage |
| rst | input | 1 | Synchronous active-high clear |
| ld_n | input | 1 | Active-low synchronous parallel load |
| en_p_n | input | 1 | Active-low count enable that does not gate the carry |
| en_t_n | input | 1 | Active-low count enable that also gates the carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| d | input | 4·STAGES | Parallel preset value |
| q | output | 4·STAGES | Current count |
| tc_n | output | 1 | Active-low terminal-count carry of the whole chain |

## Verification
The bench sweeps the full 12-bit range of a three-stage chain in both directions and compares every cycle with an arithmetic model. A stage that failed to pass its carry to the next stage would show a wrong upper nibble at 0x00F→0x010 or at 0x100→0x0FF. A missing wrap would stick at 0xFFF or at 0x000. Loads are applied with the enables both active and inactive, so a design that let counting win over loading would be off by one. The carry is checked with `en_p_n` high, where a design that gated the carry with the wrong enable would leave it high. The direction is also toggled between edges at 0x000 and at 0xFFF, where a registered carry would lag by one cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int unsigned UPDN_STAGE_W = 4;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_term.sv
// Terminal-value detector for one stage: all ones counting up, all zeros down.
module updn_term
  import updn_pkg::*;
#(
  parameter int unsigned W = UPDN_STAGE_W
) (
  input  logic [W-1:0] cnt,
  input  logic         up,
  output logic         term
);
  always_comb begin
    unique case (dir_e'(up))
      DIR_UP:   term = &cnt;
      default:  term = ~|cnt;
    endcase
  end
endmodule

// File: rtl/updn_carry.sv
// Active-low carry gate: low only when the incoming enable is low and the stage is terminal.
module updn_carry (
  input  logic t_n,
  input  logic term,
  output logic tc_n
);
  assign tc_n = ~(~t_n & term);
endmodule

// File: rtl/updn_stage.sv
// One presettable up/down stage with synchronous load and dual active-low enables.
module updn_stage
  import updn_pkg::*;
#(
  parameter int unsigned W = UPDN_STAGE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic         p_n,
  input  logic         t_n,
  input  logic         up,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         term
);
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nx;
  logic         advance;

  assign advance = ~p_n & ~t_n;

  always_comb begin
    cnt_nx = cnt_r;
    if (!ld_n)        cnt_nx = d;
    else if (advance) cnt_nx = (dir_e'(up) == DIR_UP) ? cnt_r + 1'b1 : cnt_r - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_r <= '0;
    else     cnt_r <= cnt_nx;
  end

  updn_term #(.W(W)) u_term (
    .cnt  (cnt_r),
    .up   (up),
    .term (term)
  );

  assign q = cnt_r;
endmodule

// File: rtl/updn_chain.sv
// Chain of identical stages forming one wide synchronous up/down counter.
module updn_chain
  import updn_pkg::*;
#(
  parameter int unsigned W         = UPDN_STAGE_W,
  parameter int unsigned STAGES    = 3,
  parameter bit          LOOKAHEAD = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_n,
  input  logic                  en_p_n,
  input  logic                  en_t_n,
  input  logic                  up,
  input  logic [W*STAGES-1:0]   d,
  output logic [W*STAGES-1:0]   q,
  output logic                  tc_n
);
  localparam int unsigned TOTAL_W = W * STAGES;

  logic [STAGES-1:0] term;
  logic [STAGES-1:0] t_vec;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign t_vec[k] = en_t_n;
    end else if (LOOKAHEAD) begin : g_look
      // every stage sees the full lower-stage terminal product in parallel
      assign t_vec[k] = en_t_n | ~(&term[k-1:0]);
    end else begin : g_ripple
      updn_carry u_c (
        .t_n  (t_vec[k-1]),
        .term (term[k-1]),
        .tc_n (t_vec[k])
      );
    end

    updn_stage #(.W(W)) u_s (
      .clk  (clk),
      .rst  (rst),
      .ld_n (ld_n),
      .p_n  (en_p_n),
      .t_n  (t_vec[k]),
      .up   (up),
      .d    (d[k*W +: W]),
      .q    (q[k*W +: W]),
      .term (term[k])
    );
  end

  updn_carry u_out (
    .t_n  (t_vec[STAGES-1]),
    .term (term[STAGES-1]),
    .tc_n (tc_n)
  );

  if (TOTAL_W < 2) begin : g_bad
    initial $error("updn_chain: TOTAL_W too small");
  end
endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                ld_n,
  input logic                en_p_n,
  input logic                en_t_n,
  input logic                up,
  input logic [W*STAGES-1:0] d,
  input logic [W*STAGES-1:0] q,
  input logic                tc_n
);
  localparam int unsigned TW = W * STAGES;

  logic [TW-1:0] q_inc;
  logic [TW-1:0] q_dec;
  logic          at_end;

  assign q_inc  = q + 1'b1;
  assign q_dec  = q - 1'b1;
  assign at_end = up ? (q == {TW{1'b1}}) : (q == {TW{1'b0}});

  a_r1_clear: assert property (@(posedge clk) rst |=> (q == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> (q == $past(d)));

  a_r3_up: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !en_p_n && !en_t_n && up) |=> (q == $past(q_inc)));

  a_r4_down: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !en_p_n && !en_t_n && !up) |=> (q == $past(q_dec)));

  a_r5_hold_p: assert property (@(posedge clk) disable iff (rst)
    (ld_n && en_p_n) |=> $stable(q));

  a_r6_hold_t: assert property (@(posedge clk) disable iff (rst)
    (ld_n && en_t_n) |=> $stable(q));

  a_r6_carry_off: assert property (@(posedge clk) disable iff (rst)
    en_t_n |-> tc_n);

  a_r7_carry_level: assert property (@(posedge clk) disable iff (rst)
    tc_n == !(!en_t_n && at_end));
endmodule

bind updn_chain updn_chain_chk #(.W(W), .STAGES(STAGES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ld_n   (ld_n),
  .en_p_n (en_p_n),
  .en_t_n (en_t_n),
  .up     (up),
  .d      (d),
  .q      (q),
  .tc_n   (tc_n)
);

// File: tb/sim_updn_chain.sv
module sim_updn_chain;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int STAGES     = 3;
  localparam int TW         = W * STAGES;
  localparam logic [TW-1:0] ALL1 = {TW{1'b1}};

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_n, en_p_n, en_t_n, up;
  logic [TW-1:0] d;
  logic [TW-1:0] q;
  logic          tc_n;

  logic [TW-1:0] ref_q;
  int            n_run  = 0;
  int            n_fail = 0;
  bit            done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_chain #(.W(W), .STAGES(STAGES)) u0 (
    .clk(clk), .rst(rst), .ld_n(ld_n), .en_p_n(en_p_n), .en_t_n(en_t_n),
    .up(up), .d(d), .q(q), .tc_n(tc_n)
  );

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_tc();
    logic term;
    term = up ? (ref_q == ALL1) : (ref_q == '0);
    return !(!en_t_n && term);
  endfunction

  // inputs are set at a falling edge; apply one rising edge and check at the next falling edge
  task automatic step(input string tag);
    logic [TW-1:0] nx;
    nx = ref_q;
    if (rst)                        nx = '0;
    else if (!ld_n)                 nx = d;
    else if (!en_p_n && !en_t_n)    nx = up ? ref_q + 1'b1 : ref_q - 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_q = nx;
    chk(tag, q, ref_q);
    chk({tag, " carry R7"}, {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, exp_tc()});
  endtask

  task automatic load(input logic [TW-1:0] v, input logic p, input logic t);
    ld_n = 1'b0; en_p_n = p; en_t_n = t; d = v;
    step("R2 load");
    ld_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ld_n = 1'b1; en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1; d = 12'hAAA;
    ref_q = '0;
    @(negedge clk);
    step("R1 reset");
    ld_n = 1'b0;
    step("R1 reset over load");
    ld_n = 1'b1;
    rst = 1'b0;

    // R3: full upward sweep with wrap
    up = 1'b1;
    for (int i = 0; i < (1 << TW) + 3; i++) step("R3 count up");

    // R2: load has priority over active enables
    load(12'h123, 1'b0, 1'b0);
    load(12'hFFF, 1'b1, 1'b1);

    // R5 + R7: P high holds, carry still low at all ones counting up
    en_p_n = 1'b1; en_t_n = 1'b0; up = 1'b1;
    for (int i = 0; i < 6; i++) step("R5 hold P");
    chk("R7 carry with P high", {{(TW-1){1'b0}}, tc_n}, '0);

    // R6: T high holds and forces carry high
    en_p_n = 1'b0; en_t_n = 1'b1;
    for (int i = 0; i < 6; i++) step("R6 hold T");
    chk("R6 carry off", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, 1'b1});

    // R4: full downward sweep with wrap
    en_t_n = 1'b0; up = 1'b0;
    for (int i = 0; i < (1 << TW) + 3; i++) step("R4 count down");

    // R3/R4 inter-stage boundaries
    load(12'h00F, 1'b1, 1'b0);
    en_p_n = 1'b0; up = 1'b1;
    step("R3 stage carry 00F->010");
    load(12'h0FF, 1'b1, 1'b0);
    en_p_n = 1'b0; up = 1'b1;
    step("R3 stage carry 0FF->100");
    up = 1'b0;
    step("R4 stage borrow 100->0FF");
    load(12'h010, 1'b0, 1'b1);
    en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b0;
    step("R4 stage borrow 010->00F");

    // R8: carry follows direction between edges
    load(12'h000, 1'b1, 1'b0);
    en_p_n = 1'b1; en_t_n = 1'b0; up = 1'b1;
    #1 chk("R8 up at zero", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, 1'b1});
    up = 1'b0;
    #1 chk("R8 down at zero", {{(TW-1){1'b0}}, tc_n}, '0);
    en_t_n = 1'b1;
    #1 chk("R8 T high at zero", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, 1'b1});
    en_t_n = 1'b0;
    step("R5 hold at zero");
    load(ALL1, 1'b1, 1'b0);
    en_p_n = 1'b1; up = 1'b0;
    #1 chk("R8 down at ones", {{(TW-1){1'b0}}, tc_n}, {{(TW-1){1'b0}}, 1'b1});
    up = 1'b1;
    #1 chk("R8 up at ones", {{(TW-1){1'b0}}, tc_n}, '0);
    step("R5 hold at ones");

    // mixed loads, counts and holds
    for (int i = 0; i < 40; i++) begin
      load(TW'(i * 97 + 5), i[0], i[1]);
      en_p_n = i[2]; en_t_n = i[3]; up = i[4];
      step("R3 R4 R5 R6 mixed");
      step("R3 R4 R5 R6 mixed");
    end

    // R1: reset in mid-run
    load(12'h5A5, 1'b0, 1'b0);
    rst = 1'b1;
    step("R1 mid reset");
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule